// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block takes configuration words from a three-wire serial port (shift clock, data and a latch strobe) and places them into one of two holding registers. All three serial lines are brought into the system clock domain through a synchroniser. Data bits are collected on rising edges of the shift clock while the latch strobe is low. When the latch strobe rises, the last 18 bits collected are transferred. The lowest bit of the word, which is the final bit shifted in, selects the destination. A value of 0 selects the 17-bit main-divider register and a value of 1 selects the reference register.

The reference register is split into control outputs: a 10-bit reference divide ratio, a charge-pump high-impedance control, a phase-detector polarity control and a lock-detect output select. A reference word whose ratio is below the legal minimum of 2 is rejected as a whole, and an error flag pulses for one cycle. Each accepted transfer raises a one-cycle strobe for the register it loaded, so downstream counters know when to reload.

Control is a three-state machine:
- `ST_IDLE` waits with the latch strobe high. It moves to `ST_SHIFT` when the synchronised strobe is seen low.
- `ST_SHIFT` accepts shift-clock edges. It moves to `ST_COMMIT` on a rising edge of the latch strobe.
- `ST_COMMIT` performs the transfer for one cycle and always returns to `ST_IDLE`.

Top module: `cfg_word_loader`

## Requirements
- R1: After reset the outputs are as follows. `ref_ratio` is 2, `cp_hiz` is 1, `pd_pos` is 0, `lock_sel` is 0 and `main_word` is 0. All strobes are low.
- R2: Bits are shifted in most significant bit first on each rising edge of `ser_clk` while `ser_le` is low. Word bit 0 (the last bit shifted) is the address. With address 0, word bits 17..1 are loaded into `main_word`.
- R3: With address 1, word bits 10..1 are loaded into `ref_ratio` as plain binary. Word bit 11 drives `cp_hiz` (1 = high impedance). Word bit 12 drives `pd_pos` (1 = positive). Word bit 13 drives `lock_sel`. Word bits 17..14 have no effect.
- R4: A reference word whose ratio field is 0 or 1 leaves all reference outputs unchanged. It raises `ratio_err` for exactly one cycle and does not raise `ref_upd`. `ref_ratio` is never below 2.
- R5: Each accepted transfer raises exactly one strobe for exactly one cycle: `main_upd` for address 0, `ref_upd` for address 1. At most one of `ref_upd`, `main_upd` and `ratio_err` is high in any cycle.
- R6: Edges on `ser_clk` while `ser_le` is high do not change the collected word.
- R7: A transfer happens only on a rising edge of `ser_le`. When more than 18 bits are shifted, only the last 18 are used.
- R8: Loading one holding register leaves the other register's outputs unchanged.
- R9: Ratio values 2 and 1023 are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, sampled on shift-clock rise |
| ser_le | input | 1 | Latch strobe; low while shifting, rising edge transfers |
| ref_ratio | output | 10 | Reference divide ratio |
| cp_hiz | output | 1 | Charge pump high impedance when 1 |
| pd_pos | output | 1 | Phase detector polarity, 1 = positive |
| lock_sel | output | 1 | Lock-detect output select |
| main_word | output | 17 | Raw main-divider register contents |
| ref_upd | output | 1 | One-cycle pulse on reference register load |
| main_upd | output | 1 | One-cycle pulse on main register load |
| ratio_err | output | 1 | One-cycle pulse on rejected reference word |

## Verification
The bound checker watches the following properties on every cycle:
- the ratio never falls below 2;
- the three strobes are mutually exclusive and each lasts a single cycle;
- each holding register's outputs stay stable in every cycle where its own strobe is low.

Some behaviours can only be shown by the bench's scenarios, because they need a whole serial word and a known expected value. These are:
- the bit ordering of the shifted word;
- the field decoding of the reference word;
- the rejection of the prohibited ratios 0 and 1;
- the fact that shift-clock edges are ignored while the latch strobe is high;
- the retention of only the final 18 bits of an over-long word.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgl_shreg.sv
module cfgl_shreg #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
    end
endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
    import cfgl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_s,
    input  logic sck_s,
    output logic shift_en,
    output logic commit
);
    ld_state_e state_q, state_d;
    logic      le_d, sck_d;
    logic      le_rise, sck_rise;

    // previous synchronised levels for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            le_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            le_d  <= le_s;
            sck_d <= sck_s;
        end
    end

    assign le_rise  = le_s & ~le_d;
    assign sck_rise = sck_s & ~sck_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!le_s)   state_d = ST_SHIFT;
            ST_SHIFT:  if (le_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_SHIFT:  shift_en = sck_rise & ~le_s;
            ST_COMMIT: commit   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgl_regs.sv
module cfgl_regs #(
    parameter int WORD_W    = 18,
    parameter int RATIO_W   = 10,
    parameter int RATIO_MIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [WORD_W-1:0]  word,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic               cp_hiz,
    output logic               pd_pos,
    output logic               lock_sel,
    output logic [WORD_W-2:0]  main_word,
    output logic               ref_upd,
    output logic               main_upd,
    output logic               ratio_err
);
    localparam int MAIN_W = WORD_W - 1;
    localparam int KEEP_W = RATIO_W + 3;   // ratio, tri-state, polarity, lock select
    localparam int CP_B   = RATIO_W;
    localparam int PD_B   = RATIO_W + 1;
    localparam int LK_B   = RATIO_W + 2;
    localparam logic [KEEP_W-1:0] REF_RST =
        KEEP_W'((64'd1 << CP_B) | 64'(RATIO_MIN));

    logic [KEEP_W-1:0] ref_q;
    logic [KEEP_W-1:0] ref_cand;
    logic              addr_ref, ratio_ok;

    assign addr_ref = word[0];
    assign ref_cand = word[KEEP_W:1];
    assign ratio_ok = ref_cand[RATIO_W-1:0] >= RATIO_W'(RATIO_MIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q     <= REF_RST;
            main_word <= '0;
            ref_upd   <= 1'b0;
            main_upd  <= 1'b0;
            ratio_err <= 1'b0;
        end else begin
            ref_upd   <= 1'b0;
            main_upd  <= 1'b0;
            ratio_err <= 1'b0;
            if (commit) begin
                if (addr_ref) begin
                    if (ratio_ok) begin
                        ref_q   <= ref_cand;
                        ref_upd <= 1'b1;
                    end else begin
                        ratio_err <= 1'b1;
                    end
                end else begin
                    main_word <= word[MAIN_W:1];
                    main_upd  <= 1'b1;
                end
            end
        end
    end

    assign ref_ratio = ref_q[RATIO_W-1:0];
    assign cp_hiz    = ref_q[CP_B];
    assign pd_pos    = ref_q[PD_B];
    assign lock_sel  = ref_q[LK_B];
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader #(
    parameter int WORD_W      = 18,
    parameter int RATIO_W     = 10,
    parameter int RATIO_MIN   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_le,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic               cp_hiz,
    output logic               pd_pos,
    output logic               lock_sel,
    output logic [WORD_W-2:0]  main_word,
    output logic               ref_upd,
    output logic               main_upd,
    output logic               ratio_err
);
    logic [2:0]        ser_s;
    logic              shift_en, commit;
    logic [WORD_W-1:0] word;

    // bit 2: latch strobe (resets high), bit 1: shift clock, bit 0: data
    cfgl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_le, ser_clk, ser_dat}),
        .q     (ser_s)
    );

    cfgl_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .le_s     (ser_s[2]),
        .sck_s    (ser_s[1]),
        .shift_en (shift_en),
        .commit   (commit)
    );

    cfgl_shreg #(.WORD_W(WORD_W)) i_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (ser_s[0]),
        .word     (word)
    );

    cfgl_regs #(.WORD_W(WORD_W), .RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .word      (word),
        .ref_ratio (ref_ratio),
        .cp_hiz    (cp_hiz),
        .pd_pos    (pd_pos),
        .lock_sel  (lock_sel),
        .main_word (main_word),
        .ref_upd   (ref_upd),
        .main_upd  (main_upd),
        .ratio_err (ratio_err)
    );
endmodule

// File: rtl/cfgl_chk.sv
module cfgl_chk #(
    parameter int RATIO_W   = 10,
    parameter int MAIN_W    = 17,
    parameter int RATIO_MIN = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] ref_ratio,
    input logic               cp_hiz,
    input logic               pd_pos,
    input logic               lock_sel,
    input logic [MAIN_W-1:0]  main_word,
    input logic               ref_upd,
    input logic               main_upd,
    input logic               ratio_err
);
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_upd, main_upd, ratio_err}));

    p_upd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_upd || main_upd) |=> !(ref_upd || main_upd));

    p_ratio_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ratio >= RATIO_W'(RATIO_MIN));

    p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_err |=> !ratio_err);

    p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd |-> $stable({ref_ratio, cp_hiz, pd_pos, lock_sel}));

    p_main_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !main_upd |-> $stable(main_word));
endmodule

bind cfg_word_loader cfgl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_ratio (ref_ratio),
    .cp_hiz    (cp_hiz),
    .pd_pos    (pd_pos),
    .lock_sel  (lock_sel),
    .main_word (main_word),
    .ref_upd   (ref_upd),
    .main_upd  (main_upd),
    .ratio_err (ratio_err)
);

// File: tb/test_cfg_word_loader.sv
module test_cfg_word_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_le = 1'b1;
    logic [9:0]  ref_ratio;
    logic        cp_hiz, pd_pos, lock_sel;
    logic [16:0] main_word;
    logic        ref_upd, main_upd, ratio_err;

    int n_cmp = 0;
    int n_bad = 0;
    int c_ref = 0, c_main = 0, c_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_word_loader i_cfg_word_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .cp_hiz(cp_hiz), .pd_pos(pd_pos), .lock_sel(lock_sel),
        .main_word(main_word), .ref_upd(ref_upd), .main_upd(main_upd), .ratio_err(ratio_err)
    );

    // count high cycles of each strobe
    always @(posedge clk) begin
        if (ref_upd)   c_ref  <= c_ref + 1;
        if (main_upd)  c_main <= c_main + 1;
        if (ratio_err) c_err  <= c_err + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sck(input logic b);
        ser_dat = b;  idle(4);
        ser_clk = 1'b1; idle(4);
        ser_clk = 1'b0; idle(4);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        ser_le = 1'b0; idle(4);
        for (int i = n - 1; i >= 0; i--) pulse_sck(v[i]);
    endtask

    task automatic latch;
        ser_le = 1'b1; idle(10);
    endtask

    function automatic logic [17:0] ref_w(input logic [3:0] dc, input logic lk,
                                         input logic pd, input logic cp, input logic [9:0] r);
        return {dc, lk, pd, cp, r, 1'b1};
    endfunction

    task automatic t_reset;
        check("R1 ref_ratio", 32'(ref_ratio), 32'd2);
        check("R1 cp_hiz", 32'(cp_hiz), 32'd1);
        check("R1 pd_pos", 32'(pd_pos), 32'd0);
        check("R1 lock_sel", 32'(lock_sel), 32'd0);
        check("R1 main_word", 32'(main_word), 32'd0);
        check("R1 strobes", 32'({ref_upd, main_upd, ratio_err}), 32'd0);
    endtask

    task automatic t_main_load;
        int m0 = c_main, r0 = c_ref;
        shift_bits(32'({17'h1A5C3, 1'b0}), 18);
        check("R7 no transfer before latch rise", 32'(main_word), 32'd0);
        latch();
        check("R2 main_word", 32'(main_word), 32'h1A5C3);
        check("R5 main_upd one cycle", 32'(c_main - m0), 32'd1);
        check("R5 no ref_upd on main load", 32'(c_ref - r0), 32'd0);
        check("R8 ref untouched by main load", 32'({lock_sel, pd_pos, cp_hiz, ref_ratio}), 32'h402);
    endtask

    task automatic t_ref_load;
        int m0 = c_main, r0 = c_ref;
        shift_bits(32'(ref_w(4'hF, 1'b1, 1'b1, 1'b0, 10'h2AB)), 18);
        latch();
        check("R3 ref_ratio", 32'(ref_ratio), 32'h2AB);
        check("R3 cp_hiz", 32'(cp_hiz), 32'd0);
        check("R3 pd_pos", 32'(pd_pos), 32'd1);
        check("R3 lock_sel", 32'(lock_sel), 32'd1);
        check("R5 ref_upd one cycle", 32'(c_ref - r0), 32'd1);
        check("R8 main untouched by ref load", 32'(main_word), 32'h1A5C3);
        check("R5 no main_upd on ref load", 32'(c_main - m0), 32'd0);
    endtask

    task automatic t_bounds;
        shift_bits(32'(ref_w(4'h0, 1'b0, 1'b0, 1'b1, 10'd1023)), 18); latch();
        check("R9 ratio 1023", 32'(ref_ratio), 32'd1023);
        check("R9 cp_hiz 1", 32'(cp_hiz), 32'd1);
        shift_bits(32'(ref_w(4'h5, 1'b0, 1'b1, 1'b0, 10'd2)), 18); latch();
        check("R9 ratio 2", 32'(ref_ratio), 32'd2);
        check("R3 pd_pos after ratio 2 word", 32'(pd_pos), 32'd1);
    endtask

    task automatic t_reject;
        int e0 = c_err, r0 = c_ref;
        shift_bits(32'(ref_w(4'h0, 1'b1, 1'b0, 1'b1, 10'd1)), 18); latch();
        check("R4 ratio 1 rejected", 32'({lock_sel, pd_pos, cp_hiz, ref_ratio}), 32'h802);
        shift_bits(32'(ref_w(4'h0, 1'b1, 1'b0, 1'b1, 10'd0)), 18); latch();
        check("R4 ratio 0 rejected", 32'({lock_sel, pd_pos, cp_hiz, ref_ratio}), 32'h802);
        check("R4 ratio_err pulses", 32'(c_err - e0), 32'd2);
        check("R4 no ref_upd on reject", 32'(c_ref - r0), 32'd0);
    endtask

    task automatic t_le_high;
        int m0;
        shift_bits(32'({17'h0F0F0, 1'b0}), 18); latch();
        m0 = c_main;
        for (int i = 17; i >= 0; i--) pulse_sck(ref_w(4'h0, 1'b0, 1'b0, 1'b0, 10'd9)[i]);
        ser_le = 1'b0; idle(6);
        latch();
        check("R6 word kept while latch high", 32'(main_word), 32'h0F0F0);
        check("R6 reload strobes main", 32'(c_main - m0), 32'd1);
        check("R6 ref unchanged", 32'(ref_ratio), 32'd2);
    endtask

    task automatic t_long_word;
        shift_bits({10'h3FF, 4'hA, 17'h05A5A, 1'b0}, 32); latch();
        check("R7 last 18 bits kept", 32'(main_word), 32'h05A5A);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_main_load();
        t_ref_load();
        t_bounds();
        t_reject();
        t_le_high();
        t_long_word();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule